// File: doc/BRIEF.md
# Per-CPU Level Interrupt Masking Controller

This block collects a parameterized group of level-sensitive peripheral interrupt lines, 64 to 160 of them in 32-bit words, and presents one interrupt output per CPU. Every CPU owns a private register bank holding its own mask. An input reaches a CPU only when that CPU's bank has it unmasked. A source can therefore be steered to one CPU, to several CPUs, or to none by unmasking it in the chosen banks. The block has no edge detection, no polarity control, no priority logic and no queueing. A high input is pending for as long as it stays high, and software reads all status words to find which lines are active.

Masks change only through write-one-to-set and write-one-to-clear registers. Two CPUs or two drivers can therefore change different bits without a read-modify-write race. A bank is selected by a CPU index on a small 32-bit register bus, and the byte offset picks the register inside that bank. A combinational wake output rises whenever any unmasked source is pending in any bank, so it can bring a sleeping system back even with the clock stopped.

Bank layout for W words (W = NUM_IRQ/32): status words at byte offsets 4k, mask-status at 4W+4k, mask-set at 8W+4k, mask-clear at 12W+4k, with k = 0..W-1. With the default 96 inputs a bank spans 0x30 bytes.

Top module: `lvl_irq_mask_top`

## Requirements
- R1: A read of the status register at offset 4k returns the live levels irqIn[32k+31:32k] in any bank, whatever the mask holds.
- R2: After reset every mask bit of every bank reads 1 through mask-status (offset 4W+4k), and cpuIrq and wakeOut are 0 even while inputs are high.
- R3: A write to mask-set (offset 8W+4k) sets the mask bits of word k in the selected bank wherever the write data is 1. Bits written as 0 keep their value.
- R4: A write to mask-clear (offset 12W+4k) clears the mask bits of word k in the selected bank wherever the write data is 1. Bits written as 0 keep their value.
- R5: Reads of the mask-set and mask-clear registers return 0.
- R6: Writes to status or mask-status registers, to offsets of 16W or more, or to addresses with regAddr[1:0] not 00 leave every mask unchanged. Reads of the last two kinds return 0.
- R7: A write to one bank never changes the mask of another bank.
- R8: cpuIrq[c] is a register that loads, on every clock edge, the OR over all words of (irqIn AND NOT mask of bank c). It therefore reflects a mask or input change one cycle later.
- R9: wakeOut is the combinational OR over all banks of the pending unmasked sources, and it changes with the inputs without a clock edge.
- R10: Inputs are not latched. cpuIrq[c] stays high while an unmasked input stays high, and falls one cycle after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_IRQ | Level interrupt inputs, high means pending |
| regCpu | input | CPU_W | Bank (CPU) select for the register access |
| regAddr | input | ADDR_W | Byte offset inside the selected bank |
| regWe | input | 1 | Write enable, acts on the clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| cpuIrq | output | NUM_CPUS | Registered interrupt output, one per CPU |
| wakeOut | output | 1 | Combinational wake request |

## Verification
The assertions check four rules on every cycle. A raised CPU output must be backed by a wake level one cycle earlier. No CPU output is high after a cycle with all inputs low. Wake never rises with all inputs low. The mask-set and mask-clear registers always read as zero. The scenarios alone show the per-bank mask contents: that set and clear touch only the 1 bits, that one bank's write leaves the other alone, and that writes to read-only, misaligned and unmapped addresses are ignored. Those can only be seen by reading mask-status back and watching cpuIrq after each access.

// File: rtl/lvl_irq_mask_pkg.sv
package lvl_irq_mask_pkg;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_e;

  // strobes from decode to the mask datapath; bank up to 16, word up to 8
  typedef struct packed {
    logic       setStb;
    logic       clrStb;
    rdSel_e     rdSel;
    logic [3:0] bank;
    logic [2:0] word;
  } regCtl_t;

endpackage

// File: rtl/lvl_irq_mask_ctrl.sv
module lvl_irq_mask_ctrl
  import lvl_irq_mask_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int CPU_W     = 1,
  parameter int ADDR_W    = 6
) (
  input  logic [CPU_W-1:0]  regCpu,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regCtl_t           ctl
);

  localparam int OFF_W = ADDR_W - 1;
  localparam logic [OFF_W-1:0] LIM_STAT = OFF_W'(NUM_WORDS);
  localparam logic [OFF_W-1:0] LIM_MASK = OFF_W'(2 * NUM_WORDS);
  localparam logic [OFF_W-1:0] LIM_SET  = OFF_W'(3 * NUM_WORDS);
  localparam logic [OFF_W-1:0] LIM_CLR  = OFF_W'(4 * NUM_WORDS);

  logic [OFF_W-1:0] wordOff;
  logic             aligned;

  assign wordOff = {1'b0, regAddr[ADDR_W-1:2]};
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    ctl        = '0;
    ctl.rdSel  = RD_ZERO;
    ctl.bank   = 4'(regCpu);
    if (aligned) begin
      if (wordOff < LIM_STAT) begin
        ctl.rdSel = RD_STATUS;
        ctl.word  = 3'(wordOff);
      end else if (wordOff < LIM_MASK) begin
        ctl.rdSel = RD_MASK;
        ctl.word  = 3'(wordOff - LIM_STAT);
      end else if (wordOff < LIM_SET) begin
        ctl.setStb = regWe;
        ctl.word   = 3'(wordOff - LIM_MASK);
      end else if (wordOff < LIM_CLR) begin
        ctl.clrStb = regWe;
        ctl.word   = 3'(wordOff - LIM_SET);
      end
    end
  end

endmodule

// File: rtl/lvl_irq_mask_dp.sv
module lvl_irq_mask_dp
  import lvl_irq_mask_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_WORDS*32-1:0]   irqIn,
  input  regCtl_t                   ctl,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_CPUS-1:0]       cpuIrq,
  output logic                      wakeOut
);

  logic [NUM_WORDS-1:0][31:0] irqW;
  logic [NUM_WORDS-1:0][31:0] maskQ [NUM_CPUS];
  logic [NUM_CPUS-1:0]        pendNow;

  assign irqW = irqIn;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [31:0] maskWord;
      logic        hitSet;
      logic        hitClr;

      assign hitSet = ctl.setStb && (ctl.bank == 4'(c)) && (ctl.word == 3'(w));
      assign hitClr = ctl.clrStb && (ctl.bank == 4'(c)) && (ctl.word == 3'(w));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       maskWord <= '1;
        else if (hitSet) maskWord <= maskWord | wdata;
        else if (hitClr) maskWord <= maskWord & ~wdata;
      end

      assign maskQ[c][w] = maskWord;
    end

    assign pendNow[c] = |(irqW & ~maskQ[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpuIrq[c] <= 1'b0;
      else       cpuIrq[c] <= pendNow[c];
    end
  end

  assign wakeOut = |pendNow;

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (ctl.bank == 4'(c) && ctl.word == 3'(w)) begin
          case (ctl.rdSel)
            RD_STATUS: rdata = irqW[w];
            RD_MASK:   rdata = maskQ[c][w];
            default:   rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/lvl_irq_mask_top.sv
module lvl_irq_mask_top
  import lvl_irq_mask_pkg::*;
#(
  parameter  int NUM_IRQ   = 96,
  parameter  int NUM_CPUS  = 2,
  localparam int NUM_WORDS = NUM_IRQ / 32,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W    = $clog2(16 * NUM_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQ-1:0]  irqIn,
  input  logic [CPU_W-1:0]    regCpu,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [NUM_CPUS-1:0] cpuIrq,
  output logic                wakeOut
);

  regCtl_t ctl;

  lvl_irq_mask_ctrl #(
    .NUM_WORDS(NUM_WORDS),
    .CPU_W    (CPU_W),
    .ADDR_W   (ADDR_W)
  ) ctrl_i (
    .regCpu (regCpu),
    .regAddr(regAddr),
    .regWe  (regWe),
    .ctl    (ctl)
  );

  lvl_irq_mask_dp #(
    .NUM_WORDS(NUM_WORDS),
    .NUM_CPUS (NUM_CPUS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .ctl    (ctl),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .cpuIrq (cpuIrq),
    .wakeOut(wakeOut)
  );

endmodule

// File: rtl/lvl_irq_mask_chk.sv
module lvl_irq_mask_chk #(
  parameter  int NUM_IRQ   = 96,
  parameter  int NUM_CPUS  = 2,
  localparam int NUM_WORDS = NUM_IRQ / 32,
  localparam int ADDR_W    = $clog2(16 * NUM_WORDS)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_IRQ-1:0]  irqIn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regRdata,
  input logic [NUM_CPUS-1:0] cpuIrq,
  input logic                wakeOut
);

  localparam logic [ADDR_W:0] SET_LO = (ADDR_W + 1)'(8 * NUM_WORDS);
  localparam logic [ADDR_W:0] CLR_HI = (ADDR_W + 1)'(16 * NUM_WORDS);

  logic [ADDR_W:0] addrExt;
  logic            inSetClr;

  assign addrExt  = {1'b0, regAddr};
  assign inSetClr = (addrExt >= SET_LO) && (addrExt < CLR_HI) && (regAddr[1:0] == 2'b00);

  // R8: a CPU output can only be high if something was pending the cycle before
  p_irq_from_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|cpuIrq) |-> $past(wakeOut));

  // R10: no latching, all inputs low one cycle ago means every output low now
  p_level_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(|irqIn)) |-> (cpuIrq == '0));

  // R9: wake needs an active input
  p_wake_needs_input_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (|irqIn));

  // R5: set and clear registers read as zero
  p_setclr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    inSetClr |-> (regRdata == 32'h0));

endmodule

bind lvl_irq_mask_top lvl_irq_mask_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_CPUS(NUM_CPUS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .irqIn   (irqIn),
  .regAddr (regAddr),
  .regRdata(regRdata),
  .cpuIrq  (cpuIrq),
  .wakeOut (wakeOut)
);

// File: tb/lvl_irq_mask_top_tb_top.sv
module lvl_irq_mask_top_tb_top;

  localparam int NUM_IRQ  = 96;
  localparam int NUM_CPUS = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic [95:0] irqIn;
  logic [0:0]  regCpu;
  logic [5:0]  regAddr;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [1:0]  cpuIrq;
  logic        wakeOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lvl_irq_mask_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPUS(NUM_CPUS)) dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regCpu(regCpu), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .cpuIrq(cpuIrq), .wakeOut(wakeOut)
  );

  typedef struct packed {
    logic [0:0]  cpu;
    logic [5:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [95:0] irq;
    logic [31:0] expRd;
    logic [1:0]  expIrq;
    logic        expWake;
    logic [3:0]  req;
  } vec_t;

  // offsets with W=3: status 0/4/8, mask-status 12/16/20, set 24/28/32, clear 36/40/44
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd12, 1'b0, 32'h0,        {32'h0, 32'h0, 32'h1}, 32'hFFFFFFFF, 2'b00, 1'b0, 4'd2},  // R2
    '{1'b1, 6'd0,  1'b0, 32'h0,        {32'h0, 32'h0, 32'h1}, 32'h00000001, 2'b00, 1'b0, 4'd1},  // R1
    '{1'b0, 6'd36, 1'b1, 32'h1,        {32'h0, 32'h0, 32'h1}, 32'h0,        2'b01, 1'b1, 4'd4},  // R4
    '{1'b0, 6'd12, 1'b0, 32'h0,        {32'h0, 32'h0, 32'h1}, 32'hFFFFFFFE, 2'b01, 1'b1, 4'd4},  // R4
    '{1'b1, 6'd12, 1'b0, 32'h0,        {32'h0, 32'h0, 32'h1}, 32'hFFFFFFFF, 2'b01, 1'b1, 4'd7},  // R7
    '{1'b0, 6'd0,  1'b0, 32'h0,        {32'h0, 32'h0, 32'h0}, 32'h0,        2'b00, 1'b0, 4'd10}, // R10
    '{1'b1, 6'd44, 1'b1, 32'h80000000, {32'h80000000, 32'h0, 32'h0}, 32'h0, 2'b10, 1'b1, 4'd5},  // R5
    '{1'b0, 6'd24, 1'b1, 32'h1,        {32'h80000000, 32'h0, 32'h1}, 32'h0, 2'b10, 1'b1, 4'd3},  // R3
    '{1'b0, 6'd12, 1'b0, 32'h0,        {32'h80000000, 32'h0, 32'h1}, 32'hFFFFFFFF, 2'b10, 1'b1, 4'd3}, // R3
    '{1'b1, 6'd8,  1'b1, 32'h0,        {32'h80000000, 32'h0, 32'h1}, 32'h80000000, 2'b10, 1'b1, 4'd6}, // R6
    '{1'b1, 6'd32, 1'b1, 32'h1,        {32'h80000000, 32'h0, 32'h1}, 32'h0, 2'b10, 1'b1, 4'd3},  // R3
    '{1'b1, 6'd20, 1'b1, 32'hFFFFFFFF, {32'h80000000, 32'h0, 32'h1}, 32'h7FFFFFFF, 2'b10, 1'b1, 4'd6}, // R6
    '{1'b1, 6'd38, 1'b1, 32'h1,        {32'h0, 32'h0, 32'h1}, 32'h0,        2'b00, 1'b0, 4'd6},  // R6
    '{1'b0, 6'd48, 1'b1, 32'hFFFFFFFF, {32'h0, 32'h0, 32'h1}, 32'h0,        2'b00, 1'b0, 4'd6},  // R6
    '{1'b1, 6'd36, 1'b1, 32'h1,        {32'h0, 32'h20, 32'h1}, 32'h0,       2'b10, 1'b1, 4'd4},  // R4
    '{1'b0, 6'd40, 1'b1, 32'h20,       {32'h0, 32'h20, 32'h1}, 32'h0,       2'b11, 1'b1, 4'd8},  // R8
    '{1'b0, 6'd4,  1'b0, 32'h0,        {32'h0, 32'h20, 32'h1}, 32'h20,      2'b11, 1'b1, 4'd1},  // R1
    '{1'b1, 6'd12, 1'b0, 32'h0,        {32'h0, 32'h20, 32'h1}, 32'hFFFFFFFE, 2'b11, 1'b1, 4'd4}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 1'b0; irqIn = '1; regCpu = '0; regAddr = '0; regWe = 1'b0; regWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset cpuIrq", 32'(cpuIrq), 32'h0);
    check("R2 reset wakeOut", 32'(wakeOut), 32'h0);
    rstN = 1'b1; irqIn = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irqIn = VECS[i].irq; regCpu = VECS[i].cpu; regAddr = VECS[i].addr;
      regWe = VECS[i].we;  regWdata = VECS[i].wdata;
      @(posedge clk);
      @(negedge clk);
      regWe = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), regRdata, VECS[i].expRd);
      check($sformatf("R%0d vec %0d cpuIrq", VECS[i].req, i), 32'(cpuIrq), 32'(VECS[i].expIrq));
      check($sformatf("R%0d vec %0d wakeOut", VECS[i].req, i), 32'(wakeOut), 32'(VECS[i].expWake));
    end

    // R9 / R8: wake falls at once, registered outputs one edge later
    irqIn = '0;
    #1;
    check("R9 wake drops without edge", 32'(wakeOut), 32'h0);
    check("R8 cpuIrq held until edge", 32'(cpuIrq), 32'h3);
    @(posedge clk);
    @(negedge clk);
    check("R10 cpuIrq falls after input", 32'(cpuIrq), 32'h0);

    irqIn = {32'h80000000, 64'h0};
    #1;
    check("R9 wake rises without edge", 32'(wakeOut), 32'h1);
    check("R8 cpuIrq not yet", 32'(cpuIrq), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 cpuIrq after edge", 32'(cpuIrq), 32'h2);

    // R2: reset mid-run restores full masking
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; regCpu = 1'b1; regAddr = 6'd20;
    #1;
    check("R2 mask after reset", regRdata, 32'hFFFFFFFF);
    check("R2 wake after reset", 32'(wakeOut), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R2 cpuIrq after reset", 32'(cpuIrq), 32'h0);

    finish_run();
  end

endmodule